// File: doc/BRIEF.md
# Sliding-Window Survivor Traceback with Low-Latency Final-Block Path

This block is the back end of a convolutional decoder. Each clock it takes one decision vector from the metric unit, with one bit per encoder state, and writes it into a ring of survivor columns four windows deep. A window is TB columns long. When a window closes, a traceback unit starts from the state the metric unit reports as best. It walks back through that window only to settle on a start state. It then walks through the window before it, collecting one decoded bit per step. The bits come out last-first, so a small LIFO turns them back into arrival order before they leave on the normal output. Three traceback units take turns, so the output is a continuous stream at a fixed latency.

A packet's last block can also be decoded without waiting for a training window. The final-block strobe is held high while that block's symbols arrive. Once it drops, a separate engine traces back at once over exactly those columns. It starts from a user-supplied state, or from the best state when that is selected. The engine sends the bits out newest-first on a reverse port, then straight away oldest-first on a direct port. A tag, the final-block strobe and the data all come out of the normal path after the same fixed delay, so dummy symbols and block ends can be recognised downstream.

Top module: `sw_traceback`

## Requirements
- R1: One decision vector is accepted every clock. Bit s of `dec_i` is the survivor choice for state s. The predecessor of state s is {dec[s], s[SW-1:1]}, and the bit decoded for a column is bit 0 of the state at that column.
- R2: Each window is decoded by a traceback that starts from `best_state_i` as sampled with the last symbol of the following window, and passes through that whole following window before it collects any bits.
- R3: Decoded bits on `data_o` leave in arrival order with `data_vld_o` high. The bit for the symbol sampled at clock edge i is presented after edge i+4·TB, and `data_vld_o` is low before then.
- R4: `tag_o` equals the `tag_i` sampled exactly 4·TB edges earlier.
- R5: `blk_o` equals the `final_i` sampled exactly 4·TB edges earlier, so the final block is also flagged on the normal path.
- R6: `final_i` may be high for any count L of consecutive cycles from 1 to TB. If its last high cycle is sampled at edge m, then `rev_vld_o` is high from edge m+2 through edge m+1+L and low otherwise.
- R7: The direct traceback starts from `tb_state_i` sampled with the last final-block symbol when `sel_best_i` is 0, and from `best_state_i` sampled at that edge when `sel_best_i` is 1.
- R8: `rev_o` gives the final-block bits newest first: after edge m+2+c it is the bit for the symbol at edge m-c.
- R9: Immediately after the reverse run, `dir_vld_o` is high for L cycles and `dir_o` gives the same bits oldest first: after edge m+2+L+e it is the bit for the symbol at edge m-L+1+e.
- R10: While reset is held, `data_vld_o`, `rev_vld_o`, `dir_vld_o`, `blk_o` and all data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_i | input | NS | Survivor decision per state for this symbol |
| best_state_i | input | SW | Lowest-cost state index for this symbol |
| tag_i | input | TAGW | User tag carried with the symbol |
| final_i | input | 1 | High while the last block of a packet arrives |
| tb_state_i | input | SW | User start state for the direct traceback |
| sel_best_i | input | 1 | 1: direct traceback starts from best_state_i |
| data_o | output | 1 | Decoded bit, normal path |
| data_vld_o | output | 1 | data_o is valid |
| tag_o | output | TAGW | Tag delayed by the decode latency |
| blk_o | output | 1 | final_i delayed by the decode latency |
| rev_o | output | 1 | Final-block bit, reverse order |
| rev_vld_o | output | 1 | rev_o is valid |
| dir_o | output | 1 | Final-block bit, forward order |
| dir_vld_o | output | 1 | dir_o is valid |

## Verification
Each normal-path result, including the tag and the delayed block flag, is due exactly 4·TB edges after its symbol was sampled. The bench indexes every expected value by edge number and compares it at the falling edge that follows. For a final block of length L that ends at edge m, the reverse bits are due from edge m+2 and the forward bits from edge m+2+L. Expected values for those edges are computed before the run by walking the stored decision vectors with the predecessor rule of R1, so valid strobes and data are checked on the exact cycle and on every cycle around it.

// File: rtl/tbk_pkg.sv
package tbk_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_TRAIN, PH_DEC, PH_EMIT} unit_ph_e;
  typedef enum logic [1:0] {DP_IDLE, DP_REV, DP_FWD} dir_ph_e;
endpackage

// File: rtl/tbk_surv_mem.sv
module tbk_surv_mem #(
  parameter int NS    = 4,
  parameter int DEPTH = 128,
  parameter int NRD   = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                     clk_i,
  input  logic [AW-1:0]            waddr_i,
  input  logic [NS-1:0]            wcol_i,
  input  logic [NRD-1:0][AW-1:0]   raddr_i,
  output logic [NRD-1:0][NS-1:0]   rcol_o
);
  logic [NS-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) mem_q[waddr_i] <= wcol_i;

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rcol_o[r] = mem_q[raddr_i[r]];
  end
endmodule

// File: rtl/tbk_unit.sv
module tbk_unit
  import tbk_pkg::*;
#(
  parameter int TB = 32,
  parameter int SW = 2,
  parameter int AW = 7,
  localparam int NS  = 1 << SW,
  localparam int TBW = $clog2(TB)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [SW-1:0] start_state_i,
  input  logic [AW-1:0] start_addr_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic [NS-1:0] rd_col_i,
  output logic          out_bit_o,
  output logic          out_vld_o
);
  unit_ph_e       ph_q;
  logic [SW-1:0]  st_q;
  logic [AW-1:0]  addr_q;
  logic [TBW-1:0] cnt_q;
  logic [TB-1:0]  lifo_q;
  logic [SW-1:0]  st_prev;
  logic           last;

  assign rd_addr_o = addr_q;
  assign st_prev   = {rd_col_i[st_q], st_q[SW-1:1]};
  assign last      = (cnt_q == TBW'(TB - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= PH_IDLE;
      st_q      <= '0;
      addr_q    <= '0;
      cnt_q     <= '0;
      lifo_q    <= '0;
      out_bit_o <= 1'b0;
      out_vld_o <= 1'b0;
    end else begin
      out_bit_o <= 1'b0;
      out_vld_o <= 1'b0;
      unique case (ph_q)
        PH_TRAIN: begin
          st_q   <= st_prev;
          addr_q <= addr_q - AW'(1);
          cnt_q  <= cnt_q + TBW'(1);
          if (last) ph_q <= PH_DEC;
        end
        PH_DEC: begin
          lifo_q[TBW'(TB - 1) - cnt_q] <= st_q[0];
          st_q   <= st_prev;
          addr_q <= addr_q - AW'(1);
          cnt_q  <= cnt_q + TBW'(1);
          if (last) ph_q <= PH_EMIT;
        end
        PH_EMIT: begin
          out_bit_o <= lifo_q[cnt_q];
          out_vld_o <= 1'b1;
          cnt_q     <= cnt_q + TBW'(1);
          if (last) ph_q <= PH_IDLE;
        end
        default: ;
      endcase
      // a new start may overlap the final emit cycle
      if (start_i) begin
        ph_q   <= PH_TRAIN;
        st_q   <= start_state_i;
        addr_q <= start_addr_i;
        cnt_q  <= '0;
      end
    end
  end

  a_r2_unit_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (ph_q == PH_IDLE) || (ph_q == PH_EMIT && last));
endmodule

// File: rtl/tbk_direct.sv
module tbk_direct
  import tbk_pkg::*;
#(
  parameter int TB = 32,
  parameter int SW = 2,
  parameter int AW = 7,
  localparam int NS  = 1 << SW,
  localparam int TBW = $clog2(TB),
  localparam int LW  = $clog2(TB + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [SW-1:0] start_state_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [LW-1:0] len_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic [NS-1:0] rd_col_i,
  output logic          rev_o,
  output logic          rev_vld_o,
  output logic          dir_o,
  output logic          dir_vld_o
);
  dir_ph_e        ph_q;
  logic [SW-1:0]  st_q;
  logic [AW-1:0]  addr_q;
  logic [TBW-1:0] cnt_q;
  logic [LW-1:0]  len_q;
  logic [TB-1:0]  lifo_q;
  logic           last;

  assign rd_addr_o = addr_q;
  assign last      = (LW'(cnt_q) == len_q - LW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= DP_IDLE;
      st_q      <= '0;
      addr_q    <= '0;
      cnt_q     <= '0;
      len_q     <= '0;
      lifo_q    <= '0;
      rev_o     <= 1'b0;
      rev_vld_o <= 1'b0;
      dir_o     <= 1'b0;
      dir_vld_o <= 1'b0;
    end else begin
      rev_o     <= 1'b0;
      rev_vld_o <= 1'b0;
      dir_o     <= 1'b0;
      dir_vld_o <= 1'b0;
      unique case (ph_q)
        DP_IDLE: if (start_i) begin
          ph_q   <= DP_REV;
          st_q   <= start_state_i;
          addr_q <= start_addr_i;
          len_q  <= len_i;
          cnt_q  <= '0;
        end
        DP_REV: begin
          rev_o         <= st_q[0];
          rev_vld_o     <= 1'b1;
          lifo_q[cnt_q] <= st_q[0];
          st_q          <= {rd_col_i[st_q], st_q[SW-1:1]};
          addr_q        <= addr_q - AW'(1);
          cnt_q         <= last ? '0 : cnt_q + TBW'(1);
          if (last) ph_q <= DP_FWD;
        end
        DP_FWD: begin
          dir_o     <= lifo_q[TBW'(len_q - LW'(1) - LW'(cnt_q))];
          dir_vld_o <= 1'b1;
          cnt_q     <= cnt_q + TBW'(1);
          if (last) ph_q <= DP_IDLE;
        end
        default: ;
      endcase
    end
  end

  a_r6_start_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> ph_q == DP_IDLE);
  a_r9_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rev_vld_o && dir_vld_o));
  a_r9_dir_after_rev: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dir_vld_o) |-> $past(rev_vld_o));
endmodule

// File: rtl/tbk_delay.sv
module tbk_delay #(
  parameter int W   = 4,
  parameter int LAT = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [LAT+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k <= LAT; k++) pipe_q[k] <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int k = 1; k <= LAT; k++) pipe_q[k] <= pipe_q[k-1];
    end
  end

  assign q_o = pipe_q[LAT];
endmodule

// File: rtl/sw_traceback.sv
module sw_traceback #(
  parameter int TB   = 32,
  parameter int SW   = 2,
  parameter int TAGW = 4,
  localparam int NS    = 1 << SW,
  localparam int NWIN  = 4,
  localparam int DEPTH = NWIN * TB,
  localparam int AW    = $clog2(DEPTH),
  localparam int TBW   = $clog2(TB),
  localparam int LW    = $clog2(TB + 1),
  localparam int NU    = 3,
  localparam int LAT   = 4 * TB
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NS-1:0]   dec_i,
  input  logic [SW-1:0]   best_state_i,
  input  logic [TAGW-1:0] tag_i,
  input  logic            final_i,
  input  logic [SW-1:0]   tb_state_i,
  input  logic            sel_best_i,
  output logic            data_o,
  output logic            data_vld_o,
  output logic [TAGW-1:0] tag_o,
  output logic            blk_o,
  output logic            rev_o,
  output logic            rev_vld_o,
  output logic            dir_o,
  output logic            dir_vld_o
);
  logic [AW-1:0]          wp_q;
  logic                   primed_q;
  logic [1:0]             bsel_q;
  logic                   win_end, tb_start;
  logic [NU:0][AW-1:0]    raddr;
  logic [NU:0][NS-1:0]    rcol;
  logic [NU-1:0]          u_bit, u_vld;
  logic                   final_q;
  logic [SW-1:0]          dst_q;
  logic [AW-1:0]          dlast_q;
  logic [LW-1:0]          dlen_q;
  logic                   pres;

  assign win_end  = &wp_q[TBW-1:0];
  assign tb_start = win_end && primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q     <= '0;
      primed_q <= 1'b0;
      bsel_q   <= '0;
    end else begin
      wp_q <= wp_q + AW'(1);
      if (win_end) primed_q <= 1'b1;
      if (tb_start) bsel_q <= (bsel_q == 2'(NU - 1)) ? '0 : bsel_q + 2'd1;
    end
  end

  tbk_surv_mem #(.NS(NS), .DEPTH(DEPTH), .NRD(NU + 1)) u_mem (
    .clk_i, .waddr_i(wp_q), .wcol_i(dec_i), .raddr_i(raddr), .rcol_o(rcol)
  );

  for (genvar u = 0; u < NU; u++) begin : g_unit
    tbk_unit #(.TB(TB), .SW(SW), .AW(AW)) u_tb (
      .clk_i, .rst_ni,
      .start_i      (tb_start && bsel_q == 2'(u)),
      .start_state_i(best_state_i),
      .start_addr_i (wp_q),
      .rd_addr_o    (raddr[u]),
      .rd_col_i     (rcol[u]),
      .out_bit_o    (u_bit[u]),
      .out_vld_o    (u_vld[u])
    );
  end

  assign data_o     = |u_bit;
  assign data_vld_o = |u_vld;

  // final-block capture: last high cycle wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      final_q <= 1'b0;
      dst_q   <= '0;
      dlast_q <= '0;
      dlen_q  <= '0;
    end else begin
      final_q <= final_i;
      if (final_i) begin
        dst_q   <= sel_best_i ? best_state_i : tb_state_i;
        dlast_q <= wp_q;
        dlen_q  <= !final_q ? LW'(1) :
                   (dlen_q == LW'(TB)) ? dlen_q : dlen_q + LW'(1);
      end
    end
  end

  tbk_direct #(.TB(TB), .SW(SW), .AW(AW)) u_dir (
    .clk_i, .rst_ni,
    .start_i      (final_q && !final_i),
    .start_state_i(dst_q),
    .start_addr_i (dlast_q),
    .len_i        (dlen_q),
    .rd_addr_o    (raddr[NU]),
    .rd_col_i     (rcol[NU]),
    .rev_o, .rev_vld_o, .dir_o, .dir_vld_o
  );

  tbk_delay #(.W(TAGW + 2), .LAT(LAT)) u_dly (
    .clk_i, .rst_ni,
    .d_i({final_i, 1'b1, tag_i}),
    .q_o({blk_o, pres, tag_o})
  );

  a_r3_one_emitter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(u_vld));
  a_r3_r4_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_vld_o == pres);
  a_r6_len_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlen_q <= LW'(TB));
endmodule

// File: tb/tb_sw_traceback.sv
module tb_sw_traceback;
  localparam int CLK_P = 10;
  localparam int TB    = 32;
  localparam int SW    = 2;
  localparam int NS    = 1 << SW;
  localparam int TAGW  = 4;
  localparam int LAT   = 4 * TB;
  localparam int NSYM  = 600;

  typedef struct packed {
    logic [15:0] start;
    logic [15:0] len;
    logic        best;
    logic        wrong;
  } scn_t;
  // final-block scenarios: start edge, length, best-select, wrong user state
  localparam scn_t SCN [4] = '{
    '{16'd100, 16'd32, 1'b0, 1'b0},
    '{16'd200, 16'd5,  1'b1, 1'b1},
    '{16'd300, 16'd1,  1'b0, 1'b1},
    '{16'd400, 16'd17, 1'b0, 1'b1}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [NS-1:0] dec_i = '0;
  logic [SW-1:0] best_state_i = '0, tb_state_i = '0;
  logic [TAGW-1:0] tag_i = '0;
  logic final_i = 1'b0, sel_best_i = 1'b0;
  logic data_o, data_vld_o, blk_o, rev_o, rev_vld_o, dir_o, dir_vld_o;
  logic [TAGW-1:0] tag_o;

  int checks = 0, errors = 0;

  logic [NS-1:0]   dec_a  [NSYM];
  logic            bit_a  [NSYM];
  logic [SW-1:0]   st_a   [NSYM];
  logic [TAGW-1:0] tag_a  [NSYM];
  logic            fin_a  [NSYM];
  logic [SW-1:0]   tbs_a  [NSYM];
  logic            sel_a  [NSYM];
  logic            erv_v  [NSYM];
  logic            erv_b  [NSYM];
  logic            edr_v  [NSYM];
  logic            edr_b  [NSYM];

  always #(CLK_P/2) clk = ~clk;

  sw_traceback #(.TB(TB), .SW(SW), .TAGW(TAGW)) dut (
    .clk_i(clk), .rst_ni, .dec_i, .best_state_i, .tag_i, .final_i,
    .tb_state_i, .sel_best_i, .data_o, .data_vld_o, .tag_o, .blk_o,
    .rev_o, .rev_vld_o, .dir_o, .dir_vld_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input int n);
    dec_i        = dec_a[n];
    best_state_i = st_a[n];
    tag_i        = tag_a[n];
    final_i      = fin_a[n];
    tb_state_i   = tbs_a[n];
    sel_best_i   = sel_a[n];
  endtask

  initial begin
    logic [15:0]   lf;
    logic [SW-1:0] sprev, st;
    logic          seq [TB];
    lf = 16'hACE1;
    sprev = '0;
    for (int n = 0; n < NSYM; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      bit_a[n] = lf[0];
      st = {sprev[SW-2:0], lf[0]};
      dec_a[n] = lf[7:4];
      dec_a[n][st] = sprev[SW-1];   // R1 predecessor rule on the true path
      st_a[n] = st;
      sprev = st;
      tag_a[n] = TAGW'(n * 7 + 3);
      fin_a[n] = 1'b0; tbs_a[n] = '0; sel_a[n] = 1'b0;
      erv_v[n] = 1'b0; erv_b[n] = 1'b0; edr_v[n] = 1'b0; edr_b[n] = 1'b0;
    end
    for (int s = 0; s < 4; s++) begin
      int m, l;
      l = int'(SCN[s].len);
      m = int'(SCN[s].start) + l - 1;
      for (int k = int'(SCN[s].start); k <= m; k++) begin
        fin_a[k] = 1'b1;
        sel_a[k] = SCN[s].best;
        tbs_a[k] = SCN[s].wrong ? st_a[k] ^ SW'(1) : st_a[k];
      end
      st = SCN[s].best ? st_a[m] : tbs_a[m];
      for (int c = 0; c < l; c++) begin
        erv_v[m+2+c] = 1'b1;
        erv_b[m+2+c] = st[0];
        seq[c] = st[0];
        st = {dec_a[m-c][st], st[SW-1:1]};
      end
      for (int e = 0; e < l; e++) begin
        edr_v[m+2+l+e] = 1'b1;
        edr_b[m+2+l+e] = seq[l-1-e];
      end
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10 data_vld", data_vld_o, 0);
    chk("R10 rev_vld", rev_vld_o, 0);
    chk("R10 dir_vld", dir_vld_o, 0);
    chk("R10 blk", blk_o, 0);
    chk("R10 data", {data_o, rev_o, dir_o, tag_o}, 0);
    rst_ni = 1'b1;
    drive(0);
    for (int n = 0; n < NSYM; n++) begin
      int i;
      @(posedge clk);
      @(negedge clk);
      i = n - LAT;
      chk("R3 data_vld", data_vld_o, (i >= 0));
      if (i >= 0) begin
        chk(fin_a[i] ? "R2 data in final block" : "R2 R3 data", data_o, bit_a[i]);
        chk("R4 tag", tag_o, tag_a[i]);
        chk("R5 blk", blk_o, fin_a[i]);
      end
      chk("R6 rev_vld", rev_vld_o, erv_v[n]);
      if (erv_v[n]) chk("R7 R8 rev", rev_o, erv_b[n]);
      chk("R9 dir_vld", dir_vld_o, edr_v[n]);
      if (edr_v[n]) chk("R9 dir", dir_o, edr_b[n]);
      if (n + 1 < NSYM) drive(n + 1);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule